// File: doc/BRIEF.md
# Thread Run-State Update Controller

This block decides, after software has changed control state, which hardware thread contexts may run and which must be held. Any write to a masked control register raises a request. The block does not act at once. It sets a pending flag, and on the following clock it evaluates every thread context in parallel. The result is a one-cycle vector of halt pulses and a one-cycle vector of restore pulses, which the pipeline consumes. The register storage lives outside this block. The block reads the per-thread halt bits, the per-thread activated bits and the configured thread count (stored minus one) as plain inputs.

A thread is in range when its index is at most the count-minus-one field. For each thread in range, the block issues a halt pulse when that thread's halt bit is set or its activated bit is clear. It issues a restore pulse when the halt bit is clear and the activated bit is set. A write that arrives while an evaluation is under way re-arms the pending flag, so that write still leads to an evaluation of its own. The block also drives the reset-time values that the surrounding register file loads into the thread and configuration fields.

Top module: `thr_run_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `upd_pending_o`, `upd_strobe_o`, `halt_pulse_o` and `restore_pulse_o` are all zero.
- R2: A cycle with `ctl_wr_i` high makes `upd_pending_o` high in the next cycle.
- R3: One cycle after `upd_pending_o` is high, `upd_strobe_o` is high for exactly that one cycle, and the pulse vectors are valid in that same cycle. A single write yields exactly one strobe.
- R4: During a strobe, bit t of `halt_pulse_o` is 1 exactly when thread t is in range and (`thr_halt_i[t]` is 1 or `thr_act_i[t]` is 0). A thread never receives a halt pulse and a restore pulse in the same cycle.
- R5: During a strobe, bit t of `restore_pulse_o` is 1 exactly when thread t is in range, `thr_halt_i[t]` is 0 and `thr_act_i[t]` is 1.
- R6: Thread t is in range when t is at most `thr_count_m1_i`. Threads above that value get no pulse of either kind.
- R7: A write in the cycle where `upd_pending_o` is high re-arms the flag, so a second strobe follows the first in the next cycle. With no further write, the flag drops after one cycle.
- R8: The status and count inputs are sampled in the cycle in which `upd_pending_o` is high. Their values in the write cycle have no effect.
- R9: The reset-value outputs are fixed. `rst_act_o` has only bit 0 set. `rst_halt_o` is all zero. `rst_dyn_o` has every bit set except bit 0. `rst_count_m1_o` equals NUM_THREADS-1 and `rst_grp_m1_o` equals NUM_GROUPS-1. `rst_tc_alloc_o` and `rst_mvp_o` are both 1.
- R10: Outside a strobe cycle, both pulse vectors are zero, whatever the status inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr_i | input | 1 | Masked control-register write occurred this cycle |
| thr_count_m1_i | input | PW | Number of threads to evaluate, minus one |
| thr_halt_i | input | NUM_THREADS | Per-thread halt bit |
| thr_act_i | input | NUM_THREADS | Per-thread activated bit |
| upd_pending_o | output | 1 | An evaluation is scheduled for this cycle |
| upd_strobe_o | output | 1 | Evaluation result valid this cycle |
| halt_pulse_o | output | NUM_THREADS | One-cycle halt request per thread |
| restore_pulse_o | output | NUM_THREADS | One-cycle restore request per thread |
| rst_act_o | output | NUM_THREADS | Reset value of the activated bits |
| rst_halt_o | output | NUM_THREADS | Reset value of the halt bits |
| rst_dyn_o | output | NUM_THREADS | Reset value of the dynamically-allocatable bits |
| rst_count_m1_o | output | PW | Reset value of the thread count minus one |
| rst_grp_m1_o | output | GW | Reset value of the processing-group count minus one |
| rst_tc_alloc_o | output | 1 | Reset value of the thread-allocation-allowed flag |
| rst_mvp_o | output | 1 | Reset value of the group-master flag |

## Verification
A new write and the evaluation of an earlier write can fall in the same cycle. This is the one place where the pending flag is both cleared and set. The bench provokes it by writing on two consecutive cycles. It then requires two strobes in a row followed by a quiet cycle, and it also checks that a lone write gives only one strobe. Input sampling is judged by presenting one status pattern in the write cycle and a different one in the pending cycle, then checking that the pulses follow the second pattern. Separately, every combination of count, halt and activated bits for four threads is swept and compared against the arithmetic rule.

// File: rtl/thr_run_pkg.sv
// Package: shared helpers for the thread run-state update controller.
// Assumes: counts passed in are at least 1.
package thr_run_pkg;

    // Width of an index field able to hold n-1, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/thr_upd_sched.sv
// Module: update scheduler.
// Holds the pending-evaluation flag. A write sets it. It clears one cycle
// later, when the evaluation runs, unless another write lands in that same
// cycle, in which case it stays set so that write is not lost.
// Assumes: the evaluation always completes in the cycle the flag is high.
module thr_upd_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    output logic pend_o
);

    logic pend_q;

    // Pending flag: set on write, consumed by the evaluation one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_i) begin
            pend_q <= 1'b1;
        end else if (pend_q) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> pend_q); // R2

    AST_PEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !wr_i) |=> !pend_q); // R7

endmodule

// File: rtl/thr_run_eval.sv
// Module: parallel thread evaluator.
// When go_i is high, decides for every thread in range whether it is halted
// or restored, and registers one-cycle pulse vectors plus a strobe.
// Assumes: the status inputs are stable and valid in the go cycle.
module thr_run_eval #(
    parameter int NT = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [PW-1:0] cnt_m1_i,
    input  logic [NT-1:0] halt_i,
    input  logic [NT-1:0] act_i,
    output logic          strobe_o,
    output logic [NT-1:0] halt_o,
    output logic [NT-1:0] rest_o
);

    logic [NT-1:0] in_rng;
    logic [NT-1:0] halt_d;
    logic [NT-1:0] rest_d;
    logic [NT-1:0] halt_q;
    logic [NT-1:0] rest_q;
    logic          strobe_q;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        localparam logic [PW:0] TIDX = (PW+1)'(t);

        // Per-thread decision: range test, then halt or restore condition.
        always_comb begin
            in_rng[t] = ({1'b0, cnt_m1_i} >= TIDX);
            halt_d[t] = in_rng[t] & (halt_i[t] | ~act_i[t]);
            rest_d[t] = in_rng[t] & ~halt_i[t] & act_i[t];
        end

        AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (halt_q[t] || rest_q[t]) |-> ($past({1'b0, cnt_m1_i}) >= TIDX)); // R6
    end

    // Result registers: pulses live for exactly the cycle after go_i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            halt_q   <= '0;
            rest_q   <= '0;
        end else begin
            strobe_q <= go_i;
            halt_q   <= go_i ? halt_d : '0;
            rest_q   <= go_i ? rest_d : '0;
        end
    end

    assign strobe_o = strobe_q;
    assign halt_o   = halt_q;
    assign rest_o   = rest_q;

    AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q & rest_q) == '0); // R4

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_q |-> (halt_q == '0 && rest_q == '0)); // R10

endmodule

// File: rtl/thr_rst_defaults.sv
// Module: reset-value generator.
// Drives the constant values that the register file loads at reset. Thread 0
// starts active. Every other thread starts dynamically allocatable. The count
// fields hold the built sizes minus one.
// Assumes: NT >= 1 and NG >= 1.
module thr_rst_defaults #(
    parameter int NT = 4,
    parameter int NG = 2,
    parameter int PW = 2,
    parameter int GW = 1
) (
    output logic [NT-1:0] act_o,
    output logic [NT-1:0] halt_o,
    output logic [NT-1:0] dyn_o,
    output logic [PW-1:0] cnt_m1_o,
    output logic [GW-1:0] grp_m1_o,
    output logic          tc_alloc_o,
    output logic          mvp_o
);

    localparam logic [NT-1:0] FIRST = NT'(1);

    // Constant reset values derived from the build parameters.
    always_comb begin
        act_o      = FIRST;
        halt_o     = '0;
        dyn_o      = ~FIRST;
        cnt_m1_o   = PW'(NT - 1);
        grp_m1_o   = GW'(NG - 1);
        tc_alloc_o = 1'b1;
        mvp_o      = 1'b1;
    end

endmodule

// File: rtl/thr_run_ctl.sv
// Module: thread run-state update controller (top).
// A control-register write schedules one evaluation for the next cycle. The
// evaluation emits per-thread halt and restore pulses. The reset values for
// the thread and configuration fields are also provided.
// Assumes: the caller raises ctl_wr_i once per masked register write.
module thr_run_ctl #(
    parameter  int NUM_THREADS = 4,
    parameter  int NUM_GROUPS  = 2,
    localparam int PW = thr_run_pkg::idx_w(NUM_THREADS),
    localparam int GW = thr_run_pkg::idx_w(NUM_GROUPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr_i,
    input  logic [PW-1:0]          thr_count_m1_i,
    input  logic [NUM_THREADS-1:0] thr_halt_i,
    input  logic [NUM_THREADS-1:0] thr_act_i,
    output logic                   upd_pending_o,
    output logic                   upd_strobe_o,
    output logic [NUM_THREADS-1:0] halt_pulse_o,
    output logic [NUM_THREADS-1:0] restore_pulse_o,
    output logic [NUM_THREADS-1:0] rst_act_o,
    output logic [NUM_THREADS-1:0] rst_halt_o,
    output logic [NUM_THREADS-1:0] rst_dyn_o,
    output logic [PW-1:0]          rst_count_m1_o,
    output logic [GW-1:0]          rst_grp_m1_o,
    output logic                   rst_tc_alloc_o,
    output logic                   rst_mvp_o
);

    logic pend;

    thr_upd_sched u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (ctl_wr_i),
        .pend_o (pend)
    );

    thr_run_eval #(
        .NT (NUM_THREADS),
        .PW (PW)
    ) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (pend),
        .cnt_m1_i (thr_count_m1_i),
        .halt_i   (thr_halt_i),
        .act_i    (thr_act_i),
        .strobe_o (upd_strobe_o),
        .halt_o   (halt_pulse_o),
        .rest_o   (restore_pulse_o)
    );

    thr_rst_defaults #(
        .NT (NUM_THREADS),
        .NG (NUM_GROUPS),
        .PW (PW),
        .GW (GW)
    ) u_dflt (
        .act_o      (rst_act_o),
        .halt_o     (rst_halt_o),
        .dyn_o      (rst_dyn_o),
        .cnt_m1_o   (rst_count_m1_o),
        .grp_m1_o   (rst_grp_m1_o),
        .tc_alloc_o (rst_tc_alloc_o),
        .mvp_o      (rst_mvp_o)
    );

    assign upd_pending_o = pend;

    AST_EVAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> upd_strobe_o); // R3

    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !upd_strobe_o); // R3

endmodule

// File: tb/test_thr_run_ctl.sv
// Bench: sweeps every count, halt and activated pattern for four threads and
// exercises write timing, re-arming and sampling.
module test_thr_run_ctl;

    localparam int N  = 4;
    localparam int G  = 2;
    localparam int PW = 2;
    localparam int GW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [PW-1:0] cnt = '0;
    logic [N-1:0]  hb = '0;
    logic [N-1:0]  ab = '0;
    logic          pend, strobe;
    logic [N-1:0]  hp, rp, d_act, d_halt, d_dyn;
    logic [PW-1:0] d_cnt;
    logic [GW-1:0] d_grp;
    logic          d_tca, d_mvp;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    thr_run_ctl #(.NUM_THREADS(N), .NUM_GROUPS(G)) i_thr_run_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(wr), .thr_count_m1_i(cnt),
        .thr_halt_i(hb), .thr_act_i(ab), .upd_pending_o(pend),
        .upd_strobe_o(strobe), .halt_pulse_o(hp), .restore_pulse_o(rp),
        .rst_act_o(d_act), .rst_halt_o(d_halt), .rst_dyn_o(d_dyn),
        .rst_count_m1_o(d_cnt), .rst_grp_m1_o(d_grp),
        .rst_tc_alloc_o(d_tca), .rst_mvp_o(d_mvp)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_halt(input int c, input logic [N-1:0] h, input logic [N-1:0] a);
        logic [N-1:0] r = '0;
        for (int t = 0; t < N; t++) r[t] = (t <= c) && (h[t] || !a[t]);
        return r;
    endfunction

    function automatic logic [N-1:0] exp_rest(input int c, input logic [N-1:0] h, input logic [N-1:0] a);
        logic [N-1:0] r = '0;
        for (int t = 0; t < N; t++) r[t] = (t <= c) && !h[t] && a[t];
        return r;
    endfunction

    // One write, status presented in the pending cycle, result checked.
    task automatic do_eval(input int c, input logic [N-1:0] h, input logic [N-1:0] a);
        @(negedge clk);
        check("R10 idle strobe", 32'(strobe), 0);
        wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        cnt = PW'(c); hb = h; ab = a;
        check("R2 pending", 32'(pend), 1);
        @(negedge clk);
        check("R3 strobe", 32'(strobe), 1);
        check("R4 halt", 32'(hp), 32'(exp_halt(c, h, a)));
        check("R5 restore", 32'(rp), 32'(exp_rest(c, h, a)));
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pending in reset", 32'(pend), 0);
        check("R1 strobe in reset", 32'(strobe), 0);
        check("R1 pulses in reset", 32'({hp, rp}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pending after reset", 32'(pend), 0);
        check("R1 pulses after reset", 32'({strobe, hp, rp}), 0);

        // R9 reset values
        check("R9 act", 32'(d_act), 32'h1);
        check("R9 halt", 32'(d_halt), 32'h0);
        check("R9 dyn", 32'(d_dyn), 32'hE);
        check("R9 count", 32'(d_cnt), N - 1);
        check("R9 groups", 32'(d_grp), G - 1);
        check("R9 flags", 32'({d_tca, d_mvp}), 32'h3);

        // R10: status changes with no write give no pulses
        for (int k = 0; k < 8; k++) begin
            hb = N'(k); ab = N'(~k); cnt = PW'(k);
            @(negedge clk);
            check("R10 no write", 32'({strobe, pend, hp, rp}), 0);
        end

        // R4 R5 R6 exhaustive sweep
        for (int c = 0; c < N; c++)
            for (int h = 0; h < (1 << N); h++)
                for (int a = 0; a < (1 << N); a++)
                    do_eval(c, N'(h), N'(a));

        // R3: a single write yields exactly one strobe
        @(negedge clk);
        wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        check("R3 single strobe", 32'(strobe), 1);
        @(negedge clk);
        check("R3 strobe one cycle", 32'({strobe, pend}), 0);

        // R7: write during the evaluation cycle re-arms
        cnt = 2'd3; hb = 4'h0; ab = 4'hF;
        @(negedge clk);
        wr = 1'b1;
        @(negedge clk);
        check("R7 pending first", 32'(pend), 1);
        @(negedge clk);
        wr = 1'b0;
        check("R7 first strobe", 32'(strobe), 1);
        check("R7 pending rearmed", 32'(pend), 1);
        @(negedge clk);
        check("R7 second strobe", 32'(strobe), 1);
        check("R7 second restore", 32'(rp), 32'hF);
        check("R7 pending dropped", 32'(pend), 0);
        @(negedge clk);
        check("R7 no third strobe", 32'(strobe), 0);

        // R8: write-cycle status is ignored, pending-cycle status is used
        @(negedge clk);
        wr = 1'b1; cnt = 2'd0; hb = 4'hF; ab = 4'h0;
        @(negedge clk);
        wr = 1'b0; cnt = 2'd3; hb = 4'h0; ab = 4'hF;
        @(negedge clk);
        hb = 4'hF; ab = 4'h0;
        check("R8 restore from pending cycle", 32'(rp), 32'hF);
        check("R8 halt from pending cycle", 32'(hp), 32'h0);
        @(negedge clk);
        check("R10 after strobe", 32'({hp, rp}), 0);

        finish_run();
    end

endmodule